// File: doc/BRIEF.md
# Delta-Sigma ADC Register Configuration Sequencer

This block loads a delta-sigma converter's control registers over a byte-wide SPI link. A host presents six register values on a parallel bus and pulses a request. The block then halts conversion and sends a lone reset command in its own chip-select frame. After that it writes the six registers one at a time. It confirms each write by reading the register back, and it repeats the write and the read until the readback matches or an attempt limit is used up.

The bit-level serialiser lives outside the block. This sequencer hands it one byte at a time with a go strobe. It waits for a done strobe that returns the byte shifted in during that exchange. The sequencer owns the active-low chip select and gates the converter's START line. It also keeps the confirmed channel-mux value in a holding register, so that later logic can rewrite it to restart the channel scan.

Top module: `adcreg_ctrl`

## Requirements
- R1: After reset, chip select is high, START, busy, done, err and spi_go are low, and the mux holding register reads 0.
- R2: A request taken while idle makes busy high on the next cycle. START equals conv_run while idle and is forced low whenever busy is high.
- R3: The first frame of every sequence is a single byte 0xC0, sent alone in its own chip-select frame.
- R4: A write frame is two bytes: the command 0x60 OR address (bits 7:5 = 011, bit 4 = 0, bits 3:0 = address), then the data byte.
- R5: A read frame is two bytes: the command 0x40 OR address (bits 7:5 = 010), then a dummy 0x00. The byte received during the second exchange is the readback.
- R6: Registers are written at addresses 0, 1, 3, 4, 5, 6 in that order, taking cfg_vals bytes 0 to 5 (byte k at bits 8k+7:8k). Address 2 is never written.
- R7: A readback that differs from the written value causes the write frame and the read frame for the same register to be repeated.
- R8: When MAX_TRIES consecutive attempts on one register all fail, err goes high, the sequence stops without touching later registers and done pulses. err stays high until the next accepted request clears it.
- R9: Chip select is low for the whole of a frame and high for at least one cycle between frames. spi_go is asserted only while chip select is low.
- R10: The mux holding register takes the value confirmed by readback at address 4 and changes at no other time.
- R11: done is a single-cycle pulse at the end of a sequence, and busy is already low in that cycle.
- R12: A request that arrives while busy is ignored. The latched values and the running sequence are not disturbed, and no second sequence follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req | input | 1 | Configuration request strobe |
| cfg_vals | input | 48 | Six register values, byte k for the k-th register in write order |
| conv_run | input | 1 | Conversion enable passed to START while idle |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_start | output | 1 | Converter START line |
| spi_go | output | 1 | Start a one-byte exchange on the serialiser |
| spi_tx_byte | output | 8 | Byte to shift out |
| spi_done | input | 1 | Exchange complete strobe |
| spi_rx_byte | input | 8 | Byte shifted in, valid with spi_done |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, one-cycle pulse |
| err | output | 1 | Attempt limit exhausted on some register |
| mux_hold | output | 8 | Last confirmed value of the channel-mux register |

## Verification
The assertions check several cycle-local rules on every cycle. START stays low while busy. Chip select frames every go strobe and rises after each frame ends. No write command ever carries address 2. done is one cycle long and never overlaps busy. err rises only after a failed readback. The mux holding register moves only on a confirmed address-4 readback, and the latched values stay frozen while busy. Some properties span whole sequences: the exact order of frames, the number of retries each injected mismatch causes, the early stop after the attempt limit, and the rejection of a mid-sequence request. Only the bench's scenarios can show these, using a converter model that corrupts chosen writes.

// File: rtl/adcreg_pkg.sv
package adcreg_pkg;
  localparam int unsigned NREG   = 6;
  localparam int unsigned SLOT_W = 3;
  localparam logic [7:0]  RESET_CMD = 8'hC0;

  typedef enum logic [1:0] {FR_RST, FR_WR, FR_RD} frame_e;
  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_GO, ST_WAIT} state_e;

  // write slot k maps to register address k, skipping address 2
  function automatic logic [3:0] slot_addr(input logic [SLOT_W-1:0] idx);
    logic [3:0] a;
    a = {1'b0, idx};
    if (idx >= 3'd2) a = a + 4'd1;
    return a;
  endfunction

  function automatic logic [7:0] cmd_byte(input frame_e f, input logic [3:0] a);
    case (f)
      FR_WR:   return {3'b011, 1'b0, a};
      FR_RD:   return {3'b010, 1'b0, a};
      default: return RESET_CMD;
    endcase
  endfunction
endpackage

// File: rtl/adcreg_bank.sv
module adcreg_bank
  import adcreg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [NREG*8-1:0]     vals_in,
  input  logic [SLOT_W-1:0]     sel,
  input  logic                  hold_we,
  output logic [7:0]            cur_val,
  output logic [7:0]            mux_hold,
  output logic [NREG*8-1:0]     vals_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    vals_q <= '0;
    else if (load) vals_q <= vals_in;
  end

  always_comb begin
    cur_val = '0;
    for (int i = 0; i < NREG; i++)
      if (sel == SLOT_W'(i)) cur_val = vals_q[i*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mux_hold <= '0;
    else if (hold_we) mux_hold <= cur_val;
  end
endmodule

// File: rtl/adcreg_fsm.sv
module adcreg_fsm
  import adcreg_pkg::*;
#(
  parameter int MAX_TRIES = 4
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_req,
  input  logic              spi_done,
  input  logic [7:0]        spi_rx_byte,
  input  logic [7:0]        cur_val,
  output logic [SLOT_W-1:0] ridx,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              cs_n,
  output logic              spi_go,
  output logic [7:0]        spi_tx_byte,
  output logic              accept,
  output logic              frame_end,
  output logic              rb_fail,
  output logic              hold_we
);
  localparam int TRY_W = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

  state_e            st_q, st_d;
  frame_e            fr_q, fr_d;
  logic              bidx_q, bidx_d;
  logic [SLOT_W-1:0] ridx_q, ridx_d;
  logic [TRY_W-1:0]  try_q, try_d;
  logic              done_q, done_d, err_q, err_d;
  logic              last_byte, rb_match, exhausted, last_slot;

  assign last_byte = (fr_q == FR_RST) || bidx_q;
  assign accept    = (st_q == ST_IDLE) && cfg_req;
  assign frame_end = (st_q == ST_WAIT) && spi_done && last_byte;
  assign rb_match  = frame_end && (fr_q == FR_RD) && (spi_rx_byte == cur_val);
  assign rb_fail   = frame_end && (fr_q == FR_RD) && (spi_rx_byte != cur_val);
  assign exhausted = rb_fail && (try_q == TRY_W'(MAX_TRIES - 1));
  assign last_slot = (ridx_q == SLOT_W'(NREG - 1));
  assign hold_we   = rb_match && (slot_addr(ridx_q) == 4'd4);

  always_comb begin
    st_d = st_q; fr_d = fr_q; bidx_d = bidx_q; ridx_d = ridx_q;
    try_d = try_q; err_d = err_q; done_d = 1'b0;
    case (st_q)
      ST_IDLE: if (accept) begin
        st_d = ST_GAP; fr_d = FR_RST; ridx_d = '0; try_d = '0; err_d = 1'b0;
      end
      ST_GAP: begin st_d = ST_GO; bidx_d = 1'b0; end
      ST_GO:  st_d = ST_WAIT;
      ST_WAIT: if (spi_done) begin
        if (!last_byte) begin
          bidx_d = 1'b1; st_d = ST_GO;
        end else begin
          st_d = ST_GAP;
          case (fr_q)
            FR_RST: fr_d = FR_WR;
            FR_WR:  fr_d = FR_RD;
            default: begin
              fr_d = FR_WR;
              if (rb_match) begin
                if (last_slot) begin st_d = ST_IDLE; done_d = 1'b1; end
                else begin ridx_d = ridx_q + 1'b1; try_d = '0; end
              end else if (exhausted) begin
                st_d = ST_IDLE; done_d = 1'b1; err_d = 1'b1;
              end else begin
                try_d = try_q + 1'b1;
              end
            end
          endcase
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; fr_q <= FR_RST; bidx_q <= 1'b0; ridx_q <= '0;
      try_q <= '0; done_q <= 1'b0; err_q <= 1'b0;
    end else begin
      st_q <= st_d; fr_q <= fr_d; bidx_q <= bidx_d; ridx_q <= ridx_d;
      try_q <= try_d; done_q <= done_d; err_q <= err_d;
    end
  end

  assign ridx   = ridx_q;
  assign busy   = (st_q != ST_IDLE);
  assign done   = done_q;
  assign err    = err_q;
  assign spi_go = (st_q == ST_GO);
  assign cs_n   = !((st_q == ST_GO) || (st_q == ST_WAIT));
  assign spi_tx_byte = !bidx_q ? cmd_byte(fr_q, slot_addr(ridx_q))
                     : ((fr_q == FR_WR) ? cur_val : 8'h00);
endmodule

// File: rtl/adcreg_ctrl.sv
module adcreg_ctrl
  import adcreg_pkg::*;
#(
  parameter int MAX_TRIES = 4
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_req,
  input  logic [NREG*8-1:0]  cfg_vals,
  input  logic               conv_run,
  output logic               adc_cs_n,
  output logic               adc_start,
  output logic               spi_go,
  output logic [7:0]         spi_tx_byte,
  input  logic               spi_done,
  input  logic [7:0]         spi_rx_byte,
  output logic               busy,
  output logic               done,
  output logic               err,
  output logic [7:0]         mux_hold
);
  logic [SLOT_W-1:0] ridx;
  logic [7:0]        cur_val;
  logic [NREG*8-1:0] vals_q;
  logic              accept, frame_end, rb_fail, hold_we;

  adcreg_fsm #(.MAX_TRIES(MAX_TRIES)) u_fsm (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .spi_done(spi_done),
    .spi_rx_byte(spi_rx_byte), .cur_val(cur_val), .ridx(ridx), .busy(busy),
    .done(done), .err(err), .cs_n(adc_cs_n), .spi_go(spi_go),
    .spi_tx_byte(spi_tx_byte), .accept(accept), .frame_end(frame_end),
    .rb_fail(rb_fail), .hold_we(hold_we)
  );

  adcreg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .load(accept), .vals_in(cfg_vals), .sel(ridx),
    .hold_we(hold_we), .cur_val(cur_val), .mux_hold(mux_hold), .vals_q(vals_q)
  );

  assign adc_start = conv_run & ~busy;
endmodule

// File: rtl/adcreg_chk.sv
module adcreg_chk
  import adcreg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              adc_start,
  input logic              adc_cs_n,
  input logic              spi_go,
  input logic [7:0]        spi_tx_byte,
  input logic [7:0]        mux_hold,
  input logic              frame_end,
  input logic              rb_fail,
  input logic              hold_we,
  input logic [NREG*8-1:0] vals_q
);
  AST_START_LOW_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !adc_start); // R2
  AST_GO_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    spi_go |-> !adc_cs_n); // R9
  AST_CS_RISES_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> adc_cs_n); // R9
  AST_NO_ADDR2_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_go && spi_tx_byte[7:5] == 3'b011) |-> (spi_tx_byte[3:0] != 4'd2)); // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R11
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_ERR_AFTER_FAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(rb_fail)); // R8
  AST_HOLD_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mux_hold) |-> $past(hold_we)); // R10
  AST_VALS_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(vals_q)); // R12
endmodule

bind adcreg_ctrl adcreg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .adc_start(adc_start), .adc_cs_n(adc_cs_n), .spi_go(spi_go),
  .spi_tx_byte(spi_tx_byte), .mux_hold(mux_hold), .frame_end(frame_end),
  .rb_fail(rb_fail), .hold_we(hold_we), .vals_q(vals_q)
);

// File: tb/sim_adcreg_ctrl.sv
module sim_adcreg_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int MAXT = 4;
  localparam int LAT  = 2;

  logic        clk, rst_n, cfg_req, conv_run, spi_done;
  logic [47:0] cfg_vals;
  logic [7:0]  spi_rx_byte, spi_tx_byte, mux_hold;
  logic        adc_cs_n, adc_start, spi_go, busy, done, err;

  adcreg_ctrl #(.MAX_TRIES(MAXT)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_vals(cfg_vals),
    .conv_run(conv_run), .adc_cs_n(adc_cs_n), .adc_start(adc_start),
    .spi_go(spi_go), .spi_tx_byte(spi_tx_byte), .spi_done(spi_done),
    .spi_rx_byte(spi_rx_byte), .busy(busy), .done(done), .err(err),
    .mux_hold(mux_hold)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  task automatic check(input bit ok, input string rq, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // converter model: register file with injectable write corruption
  logic [7:0]  regs [16];
  int          fail_left [16];
  logic [7:0]  fb [$];
  logic [15:0] got_w [$];
  int          got_n [$];
  logic [15:0] exp_w [$];
  int          exp_n [$];

  initial begin
    spi_done = 1'b0; spi_rx_byte = 8'h00;
    for (int i = 0; i < 16; i++) begin regs[i] = 8'h00; fail_left[i] = 0; end
    forever begin
      @(negedge clk);
      spi_done = 1'b0;
      if (adc_cs_n && fb.size() > 0) begin
        got_n.push_back(fb.size());
        got_w.push_back(fb.size() > 1 ? {fb[0], fb[1]} : {fb[0], 8'h00});
        fb.delete();
      end
      if (spi_go) begin
        logic [7:0] tx, rsp, cmd;
        tx = spi_tx_byte; rsp = 8'h00;
        if (fb.size() == 1) begin
          cmd = fb[0];
          if (cmd[7:5] == 3'b011) begin
            if (fail_left[cmd[3:0]] > 0) begin
              regs[cmd[3:0]] = tx ^ 8'h5A; fail_left[cmd[3:0]]--;
            end else regs[cmd[3:0]] = tx;
          end else if (cmd[7:5] == 3'b010) rsp = regs[cmd[3:0]];
        end
        fb.push_back(tx);
        repeat (LAT) @(negedge clk);
        spi_done = 1'b1; spi_rx_byte = rsp;
      end
    end
  end

  // expected frame list built from the requirements
  task automatic build_exp(input logic [47:0] v, input int fails [16],
                           output bit e_err, inout logic [7:0] e_mux);
    exp_w.delete(); exp_n.delete(); e_err = 1'b0;
    exp_n.push_back(1); exp_w.push_back(16'hC000);
    for (int k = 0; k < 6; k++) begin
      int a, tries;
      logic [7:0] d;
      a = (k < 2) ? k : k + 1;
      d = v[k*8 +: 8];
      tries = (fails[a] < MAXT) ? fails[a] + 1 : MAXT;
      for (int t = 0; t < tries; t++) begin
        exp_n.push_back(2); exp_w.push_back({8'h60 | 8'(a), d});
        exp_n.push_back(2); exp_w.push_back({8'h40 | 8'(a), 8'h00});
      end
      if (fails[a] >= MAXT) begin e_err = 1'b1; break; end
      if (a == 4) e_mux = d;
    end
  endtask

  logic [7:0] model_mux = 8'h00;

  task automatic run_cfg(input logic [47:0] v, input int fails [16],
                         input bit poke_busy, input string rq);
    bit e_err;
    int dones, cyc, a2w;
    for (int i = 0; i < 16; i++) fail_left[i] = fails[i];
    got_w.delete(); got_n.delete();
    build_exp(v, fails, e_err, model_mux);
    @(negedge clk);
    cfg_vals = v; cfg_req = 1'b1;
    @(negedge clk);
    cfg_req = 1'b0;
    check(busy == 1'b1, "R2", "busy after accept", busy, 1);
    check(adc_start == 1'b0, "R2", "START forced low", adc_start, 0);
    check(err == 1'b0, "R8", "err cleared on accept", err, 0);
    dones = 0; cyc = 0;
    while (dones == 0 && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (poke_busy && cyc == 30) begin
        cfg_vals = ~v; cfg_req = 1'b1;
      end else cfg_req = 1'b0;
      if (spi_go && adc_cs_n) check(0, "R9", "go outside frame", adc_cs_n, 0);
      if (busy && adc_start) check(0, "R2", "START while busy", adc_start, 0);
      if (done) begin
        dones++;
        check(busy == 1'b0, "R11", "busy low with done", busy, 0);
      end
    end
    cfg_req = 1'b0;
    check(dones == 1, rq, "sequence finished", dones, 1);
    @(negedge clk);
    check(done == 1'b0, "R11", "done single cycle", done, 0);
    check(adc_cs_n == 1'b1, "R9", "cs high when idle", adc_cs_n, 1);
    check(adc_start == conv_run, "R2", "START follows conv_run idle", adc_start, conv_run);
    check(got_n.size() == exp_n.size(), rq, "frame count", got_n.size(), exp_n.size());
    if (got_n.size() == exp_n.size()) begin
      for (int i = 0; i < exp_n.size(); i++) begin
        string r;
        r = (i == 0) ? "R3" : (exp_w[i][15:13] == 3'b011) ? "R4" : "R5";
        check(got_n[i] == exp_n[i], r, $sformatf("frame %0d length", i), got_n[i], exp_n[i]);
        check(got_w[i] == exp_w[i], r, $sformatf("frame %0d bytes", i), got_w[i], exp_w[i]);
      end
    end
    a2w = 0;
    foreach (got_w[i]) if (got_w[i][15:13] == 3'b011 && got_w[i][11:8] == 4'd2) a2w++;
    check(a2w == 0, "R6", "address 2 untouched", a2w, 0);
    check(err == e_err, "R8", "err flag", err, e_err);
    check(mux_hold == model_mux, "R10", "mux holding register", mux_hold, model_mux);
    if (poke_busy) begin
      repeat (20) @(negedge clk);
      check(busy == 1'b0, "R12", "no second sequence", busy, 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int f [16];
    rst_n = 1'b0; cfg_req = 1'b0; cfg_vals = '0; conv_run = 1'b0;
    repeat (3) @(negedge clk);
    check(adc_cs_n == 1'b1, "R1", "reset cs", adc_cs_n, 1);
    check(adc_start == 1'b0, "R1", "reset START", adc_start, 0);
    check({busy, done, err, spi_go} == 4'b0, "R1", "reset status", {busy, done, err, spi_go}, 0);
    check(mux_hold == 8'h00, "R1", "reset mux hold", mux_hold, 0);
    rst_n = 1'b1;
    conv_run = 1'b1;
    @(negedge clk);
    check(adc_start == 1'b1, "R2", "START idle", adc_start, 1);

    for (int i = 0; i < 16; i++) f[i] = 0;
    run_cfg(48'h6655_4433_2211, f, 1'b0, "R6");

    f[3] = 2; f[0] = 1;
    run_cfg(48'hA5C3_0F96_7E18, f, 1'b0, "R7");

    for (int i = 0; i < 16; i++) f[i] = 0;
    f[5] = MAXT;
    run_cfg(48'h1234_5678_9ABC, f, 1'b0, "R8");
    repeat (5) @(negedge clk);
    check(err == 1'b1, "R8", "err held while idle", err, 1);

    f[5] = 0; f[1] = MAXT - 1;
    run_cfg(48'hF00D_BEEF_CAFE, f, 1'b1, "R12");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule